// File: doc/BRIEF.md
# Step/Direction Microstep Sequencer

This block drives a two-channel microstepping DAC in a system that has no processor. It takes a step pulse and a direction level and turns each step into two timed write cycles on the DAC's byte-wide register port. The first write goes to channel 1 and the second to channel 2. An internal position counter moves by one on every rising edge of the step input, either up or down. The counter phase selects a sine code for channel 1 and a cosine code for channel 2. Both codes come from a quarter-wave magnitude table that is computed inside the design and folded across the four quadrants.

Each byte carries the winding polarity in its top bit and a 7-bit magnitude below it. The write strobe is active low and lasts a set number of clock cycles. Address and data are held steady around the strobe. There are two scheduling modes. Double-pulse places the two channel writes of a step as close together as the bus timing allows. Single-pulse inserts a fixed idle gap between them, so that steps issued at a steady rate produce evenly spaced writes. A step that arrives during a write pair is held in a one-deep queue. A further step on top of that sets a sticky overrun flag.

Top module: `msq_stepper_seq`

## Requirements
- R1: After reset, wr_n is 1, reg_addr is 0, reg_data is 0, overrun is 0, and the position counter is 0.
- R2: A rising edge on step_in, sampled on a clock edge, moves the position by +1 when dir_up is 1 and by -1 when dir_up is 0.
- R3: Each accepted step produces exactly two writes. The first write uses reg_addr 0 and carries the sine code of the position p. The second write uses reg_addr 1 and carries the code of phase p+Q (the cosine). reg_addr[1] is always 0.
- R4: The code of phase p is built as follows. Q = 2^QUART_BITS and P = 4Q. Take quadrant q = floor(p/Q) and k = p mod Q. Then j = k when q is even and j = Q-k when q is odd. Bits 6:0 hold round(127*sin(pi*j/(2Q))). Bit 7 is 1 when q is 2 or 3.
- R5: wr_n stays low for exactly STROBE_CYC cycles. reg_addr and reg_data do not change from the cycle before wr_n falls through the cycle after wr_n rises.
- R6: From idle, wr_n first goes low on the third clock edge after the step_in level is first driven high. In other words, the edge that samples the step is followed by two more edges.
- R7: With single_pulse at 0, the falling edges of wr_n for the two writes of a pair are STROBE_CYC+3 cycles apart.
- R8: With single_pulse at 1, the falling edges of wr_n for the two writes of a pair are STROBE_CYC+3+GAP_CYC cycles apart.
- R9: A step that arrives while a pair is in progress is queued and does not set overrun. After the current pair, one more pair is written using the position as it stands when that pair starts.
- R10: A step that arrives while a queued step is already pending sets overrun. overrun stays 1 until reset, and the position still advances for that step.
- R11: The position wraps modulo P in both directions. Stepping down from 0 gives P-1, and stepping up from P-1 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_in | input | 1 | Step pulse; each rising edge is one microstep |
| dir_up | input | 1 | Count sense: 1 counts up, 0 counts down |
| single_pulse | input | 1 | 1 selects single-pulse spacing, 0 selects double-pulse |
| wr_n | output | 1 | Active-low write strobe to the DAC |
| reg_addr | output | 2 | Register address: 0 is channel 1, 1 is channel 2 |
| reg_data | output | 8 | Bit 7 is polarity, bits 6:0 are magnitude |
| overrun | output | 1 | Sticky flag: a step was lost |

## Verification
A wrong position or quadrant fold appears in the data byte of the very next write pair. The most telling cases are near the quadrant boundaries and across the wrap at zero: a wrong polarity bit or a mirrored magnitude shows up there as soon as the pair is written. Errors in the strobe counter or the state sequence show up within one pair. They appear as a strobe length other than STROBE_CYC, a wrong spacing between the two falling edges, or data that moves while the strobe is low. Errors in queue handling show up only when steps arrive faster than a pair completes. A lost or duplicated pair, or an early or missing overrun, is visible once the queued pair has been written.

// File: rtl/msq_pkg.sv
package msq_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD,
    S_SETUP,
    S_LOW,
    S_HOLD,
    S_GAP
  } seq_state_t;

  localparam logic [1:0] ADDR_CH1 = 2'b00;
  localparam logic [1:0] ADDR_CH2 = 2'b01;
endpackage

// File: rtl/msq_pos_counter.sv
module msq_pos_counter #(
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_in,
  input  logic          dir_up,
  output logic          step_edge,
  output logic [PW-1:0] pos
);
  logic step_q;

  assign step_edge = step_in & ~step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= 1'b0;
      pos    <= '0;
    end else begin
      step_q <= step_in;
      // power-of-two period: natural wrap is modulo P in both senses
      if (step_edge) pos <= dir_up ? pos + 1'b1 : pos - 1'b1;
    end
  end
endmodule

// File: rtl/msq_wave_rom.sv
module msq_wave_rom #(
  parameter int QB = 4
) (
  input  logic [QB+1:0] phase,
  output logic [7:0]    code
);
  localparam int Q = 1 << QB;
  localparam logic [QB:0] Q_V = Q[QB:0];

  logic [6:0] rom [0:Q];

  function automatic logic [6:0] mag_of(int j);
    real a;
    a = 127.0 * $sin(3.14159265358979 * j / (2.0 * Q));
    return 7'($rtoi(a + 0.5));
  endfunction

  initial begin
    for (int i = 0; i <= Q; i++) rom[i] = mag_of(i);
  end

  logic [1:0]  quad;
  logic [QB:0] kx;
  logic [QB:0] j;

  always_comb begin
    quad = phase[QB+1:QB];
    kx   = {1'b0, phase[QB-1:0]};
    j    = quad[0] ? (Q_V - kx) : kx;
    code = {quad[1], rom[j]};
  end
endmodule

// File: rtl/msq_bus_seq.sv
module msq_bus_seq
  import msq_pkg::*;
#(
  parameter int QB         = 4,
  parameter int STROBE_CYC = 3,
  parameter int GAP_CYC    = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_edge,
  input  logic          single_pulse,
  input  logic [QB+1:0] pos,
  input  logic [7:0]    code,
  output logic [QB+1:0] rom_phase,
  output logic          wr_n,
  output logic [1:0]    reg_addr,
  output logic [7:0]    reg_data,
  output logic          overrun
);
  localparam int PW      = QB + 2;
  localparam int CNT_MAX = (STROBE_CYC > GAP_CYC) ? STROBE_CYC : GAP_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [PW-1:0] Q_OFF = PW'(1 << QB);

  seq_state_t        state;
  logic              ch;
  logic              pending;
  logic [PW-1:0]     snap;
  logic [CNT_W-1:0]  cnt;
  logic              busy;
  logic              end_pair;

  assign busy      = (state != S_IDLE);
  assign end_pair  = (state == S_HOLD) && ch;
  assign rom_phase = ch ? (snap + Q_OFF) : pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      ch       <= 1'b0;
      pending  <= 1'b0;
      overrun  <= 1'b0;
      snap     <= '0;
      cnt      <= '0;
      wr_n     <= 1'b1;
      reg_addr <= ADDR_CH1;
      reg_data <= '0;
    end else begin
      // queue bookkeeping: one step may wait, a second one is lost
      if (end_pair) begin
        pending <= pending & step_edge;
      end else if (busy && step_edge) begin
        if (pending) overrun <= 1'b1;
        pending <= 1'b1;
      end

      unique case (state)
        S_IDLE: begin
          if (step_edge) begin
            ch    <= 1'b0;
            state <= S_LOAD;
          end
        end
        S_LOAD: begin
          reg_data <= code;
          reg_addr <= ch ? ADDR_CH2 : ADDR_CH1;
          if (!ch) snap <= pos;
          state <= S_SETUP;
        end
        S_SETUP: begin
          wr_n  <= 1'b0;
          cnt   <= CNT_W'(STROBE_CYC - 1);
          state <= S_LOW;
        end
        S_LOW: begin
          if (cnt == '0) begin
            wr_n  <= 1'b1;
            state <= S_HOLD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_HOLD: begin
          if (!ch) begin
            ch <= 1'b1;
            if (single_pulse && (GAP_CYC > 0)) begin
              cnt   <= CNT_W'(GAP_CYC - 1);
              state <= S_GAP;
            end else begin
              state <= S_LOAD;
            end
          end else if (pending || step_edge) begin
            ch    <= 1'b0;
            state <= S_LOAD;
          end else begin
            state <= S_IDLE;
          end
        end
        S_GAP: begin
          if (cnt == '0) state <= S_LOAD;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/msq_stepper_seq.sv
module msq_stepper_seq #(
  parameter int QUART_BITS = 4,
  parameter int STROBE_CYC = 3,
  parameter int GAP_CYC    = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       step_in,
  input  logic       dir_up,
  input  logic       single_pulse,
  output logic       wr_n,
  output logic [1:0] reg_addr,
  output logic [7:0] reg_data,
  output logic       overrun
);
  localparam int PW = QUART_BITS + 2;

  logic          step_edge;
  logic [PW-1:0] pos;
  logic [PW-1:0] rom_phase;
  logic [7:0]    code;

  msq_pos_counter #(.PW(PW)) u_pos (
    .clk       (clk),
    .rst       (rst),
    .step_in   (step_in),
    .dir_up    (dir_up),
    .step_edge (step_edge),
    .pos       (pos)
  );

  msq_wave_rom #(.QB(QUART_BITS)) u_rom (
    .phase (rom_phase),
    .code  (code)
  );

  msq_bus_seq #(
    .QB         (QUART_BITS),
    .STROBE_CYC (STROBE_CYC),
    .GAP_CYC    (GAP_CYC)
  ) u_seq (
    .clk          (clk),
    .rst          (rst),
    .step_edge    (step_edge),
    .single_pulse (single_pulse),
    .pos          (pos),
    .code         (code),
    .rom_phase    (rom_phase),
    .wr_n         (wr_n),
    .reg_addr     (reg_addr),
    .reg_data     (reg_data),
    .overrun      (overrun)
  );
endmodule

// File: rtl/msq_stepper_seq_chk.sv
module msq_stepper_seq_chk #(
  parameter int PW         = 6,
  parameter int STROBE_CYC = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          step_edge,
  input logic          dir_up,
  input logic [PW-1:0] pos,
  input logic          wr_n,
  input logic [1:0]    reg_addr,
  input logic [7:0]    reg_data,
  input logic          overrun
);
  int low_run;

  always_ff @(posedge clk) begin
    if (rst)        low_run <= 0;
    else if (!wr_n) low_run <= low_run + 1;
    else            low_run <= 0;
  end

  AST_ADDR_HIGH_BIT_ZERO: assert property (@(posedge clk) disable iff (rst) reg_addr[1] == 1'b0); // R3
  AST_POS_MOVES: assert property (@(posedge clk) disable iff (rst)
    step_edge |=> pos == ($past(dir_up) ? $past(pos) + 1'b1 : $past(pos) - 1'b1)); // R2
  AST_SETUP_STABLE: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_n) |-> ($stable(reg_addr) && $stable(reg_data))); // R5
  AST_LOW_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!wr_n && !$fell(wr_n)) |-> ($stable(reg_addr) && $stable(reg_data))); // R5
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_n) |=> ($stable(reg_addr) && $stable(reg_data))); // R5
  AST_LOW_BOUND: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> (low_run < STROBE_CYC)); // R5
  AST_LOW_EXACT: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_n) |-> (low_run == STROBE_CYC)); // R5
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(overrun) |-> overrun); // R10
endmodule

bind msq_stepper_seq msq_stepper_seq_chk #(
  .PW         (PW),
  .STROBE_CYC (STROBE_CYC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .step_edge (step_edge),
  .dir_up    (dir_up),
  .pos       (pos),
  .wr_n      (wr_n),
  .reg_addr  (reg_addr),
  .reg_data  (reg_data),
  .overrun   (overrun)
);

// File: tb/msq_stepper_seq_test.sv
module msq_stepper_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int QB  = 4;
  localparam int Q   = 1 << QB;
  localparam int P   = 4 * Q;
  localparam int SC  = 3;
  localparam int GAP = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       step_in = 1'b0;
  logic       dir_up = 1'b1;
  logic       single_pulse = 1'b0;
  logic       wr_n;
  logic [1:0] reg_addr;
  logic [7:0] reg_data;
  logic       overrun;

  int n_tests = 0;
  int n_fail  = 0;
  int exp_pos = 0;
  int cyc     = 0;

  int wl_n = 0;
  int wl_addr [0:63];
  int wl_data [0:63];
  int wl_fall [0:63];
  int wl_low  [0:63];
  int lowc = 0;
  logic wr_prev = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  msq_stepper_seq #(.QUART_BITS(QB), .STROBE_CYC(SC), .GAP_CYC(GAP)) uut (
    .clk(clk), .rst(rst), .step_in(step_in), .dir_up(dir_up),
    .single_pulse(single_pulse), .wr_n(wr_n), .reg_addr(reg_addr),
    .reg_data(reg_data), .overrun(overrun)
  );

  // write monitor, sampled between active edges
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (wr_prev && !wr_n) begin
      if (wl_n < 64) begin
        wl_addr[wl_n] = int'(reg_addr);
        wl_data[wl_n] = int'(reg_data);
        wl_fall[wl_n] = cyc;
      end
      wl_n = wl_n + 1;
      lowc = 1;
    end else if (!wr_n) begin
      lowc = lowc + 1;
    end
    if (!wr_prev && wr_n && wl_n > 0 && wl_n <= 64) wl_low[wl_n-1] = lowc;
    wr_prev = wr_n;
  end

  function automatic int wrapp(int x);
    return ((x % P) + P) % P;
  endfunction

  function automatic int exp_code(int ph);
    int p, q, k, j, m;
    p = wrapp(ph);
    q = p / Q;
    k = p % Q;
    j = (q % 2 == 1) ? Q - k : k;
    m = $rtoi(127.0 * $sin(3.14159265358979 * j / (2.0 * Q)) + 0.5);
    return ((q >= 2) ? 128 : 0) + m;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_pair(int idx, int ph, string tag);
    chk({tag, " ch1 addr R3"}, wl_addr[idx], 0);
    chk({tag, " ch1 code R4"}, wl_data[idx], exp_code(ph));
    chk({tag, " ch2 addr R3"}, wl_addr[idx+1], 1);
    chk({tag, " ch2 code R4"}, wl_data[idx+1], exp_code(ph + Q));
    chk({tag, " strobe len R5"}, wl_low[idx], SC);
    chk({tag, " strobe len R5"}, wl_low[idx+1], SC);
  endtask

  task automatic pulse(logic d);
    @(negedge clk);
    dir_up  = d;
    step_in = 1'b1;
    @(negedge clk);
    step_in = 1'b0;
    exp_pos = wrapp(exp_pos + (d ? 1 : -1));
  endtask

  task automatic settle();
    repeat (50) @(negedge clk);
  endtask

  task automatic clear_log();
    @(negedge clk);
    wl_n = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    step_in = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_pos = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int lat;
    int p1, p3;
    void'($urandom(32'd20240611));
    do_reset();

    // R1 reset state
    chk("reset wr_n R1", int'(wr_n), 1);
    chk("reset addr R1", int'(reg_addr), 0);
    chk("reset data R1", int'(reg_data), 0);
    chk("reset overrun R1", int'(overrun), 0);

    // R6 latency, R1 start position, R7 double spacing
    clear_log();
    @(negedge clk);
    dir_up = 1'b1;
    step_in = 1'b1;
    lat = 0;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (k == 1) step_in = 1'b0;
      if (!wr_n && lat == 0) lat = k;
    end
    exp_pos = 1;
    chk("first strobe latency R6", lat, 3);
    settle();
    chk("write count R3", wl_n, 2);
    chk_pair(0, 1, "first step from zero R1");
    chk("double spacing R7", wl_fall[1] - wl_fall[0], SC + 3);

    // R11 wrap downward
    clear_log();
    pulse(1'b0);
    pulse(1'b0);
    settle();
    chk("write count R3", wl_n, 4);
    chk_pair(0, 0, "down to zero R2");
    chk_pair(2, P - 1, "wrap below zero R11");
    chk("wrap position R11", exp_pos, P - 1);

    // R11 wrap upward
    clear_log();
    pulse(1'b1);
    settle();
    chk("write count R3", wl_n, 2);
    chk_pair(0, 0, "wrap above top R11");

    // R8 single-pulse spacing
    single_pulse = 1'b1;
    clear_log();
    pulse(1'b1);
    settle();
    chk("write count R3", wl_n, 2);
    chk_pair(0, exp_pos, "single mode R8");
    chk("single spacing R8", wl_fall[1] - wl_fall[0], SC + 3 + GAP);
    single_pulse = 1'b0;

    // R9 queued step
    clear_log();
    pulse(1'b1);
    p1 = exp_pos;
    pulse(1'b1);
    settle();
    chk("queued write count R9", wl_n, 4);
    chk_pair(0, p1, "queue first R9");
    chk_pair(2, exp_pos, "queue second R9");
    chk("no overrun on one queued R9", int'(overrun), 0);

    // R10 overrun
    clear_log();
    pulse(1'b1);
    p1 = exp_pos;
    pulse(1'b1);
    pulse(1'b1);
    p3 = exp_pos;
    settle();
    chk("overrun set R10", int'(overrun), 1);
    chk("overrun write count R10", wl_n, 4);
    chk_pair(0, p1, "overrun first R10");
    chk_pair(2, p3, "overrun advances position R10");
    clear_log();
    pulse(1'b0);
    settle();
    chk("overrun sticky R10", int'(overrun), 1);
    chk_pair(0, exp_pos, "after overrun R2");

    do_reset();
    chk("overrun cleared R1", int'(overrun), 0);

    // random steps
    for (int i = 0; i < 150; i++) begin
      logic d;
      int   sp;
      d = 1'($urandom % 2);
      single_pulse = 1'($urandom % 2);
      sp = (single_pulse ? SC + 3 + GAP : SC + 3);
      clear_log();
      pulse(d);
      repeat (32 + ($urandom % 8)) @(negedge clk);
      chk("random count R3", wl_n, 2);
      chk_pair(0, exp_pos, "random R2");
      chk("random spacing R7 R8", wl_fall[1] - wl_fall[0], sp);
    end
    chk("random no overrun R9", int'(overrun), 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule